// File: doc/BRIEF.md
# Programmable DMA Channel Engine

This block is one DMA channel. It copies a run of halfword or word units from a source address to a target address over a memory bus that uses a valid/ready handshake. The programmed settings are held on static configuration inputs: start addresses, unit count, unit size, the adjust modes for each address, repeat, interrupt enable, cartridge-request option and start timing. The channel keeps its own working copies of the source address, the target address and the count. It updates these copies after every unit.

A 0-to-1 write of the enable bit loads the working copies. Depending on the timing mode, that write either starts the channel at once or leaves it waiting for a vertical-blank, horizontal-blank or special trigger pulse. Each unit is a read followed by a write. An access to the protected region below 0x0200_0000 is replaced by one idle cycle. The first unit of a block also pays a two-cycle idle penalty, except when both programmed addresses lie in the high bank.

When the block ends, the channel stops. It then either reloads its count and keeps its enable, or it drops the enable. It also pulses its interrupt lines.

Top module: `dma_channel_engine`

## Requirements
- R1: Each unit moves 4 bytes when `cfgWord`=1 and 2 bytes when 0. The bus address always has bits [1:0] cleared for word units and bit 0 cleared for halfword units, whatever the alignment of the working address.
- R2: Source adjust code 0 adds the unit size after each unit, code 1 subtracts it, and codes 2 and 3 hold the address. The working source is not reloaded when a repeated block starts again.
- R3: Target adjust code 0 adds, 1 subtracts and 2 holds. Code 3 adds during the block and restores the programmed target once the last unit is done.
- R4: A read or write whose working address is below 0x0200_0000 is never issued on the bus. The engine raises `idleCycle` for one cycle in its place. A protected read leaves the previously read data in place for the write.
- R5: When the working count equals the programmed count, the unit costs two extra `idleCycle` cycles before its read. This penalty is skipped only when bit 27 is set in both `cfgSrc` and `cfgDst`.
- R6: After the unit that takes the working count to zero, the channel goes inactive. With `cfgRepeat`=1 the working count reloads and `chanEnabled` stays 1. With `cfgRepeat`=0, `chanEnabled` clears.
- R7: A write with `enWr`=1 and `enData`=1, made while the channel is disabled, loads all three working copies from the programmed values. With timing code 0 it also makes the channel active at once. A write with `enData`=0 disables the channel and makes it inactive.
- R8: An enabled channel with timing code 1 is activated only by `vblankPulse`, code 2 only by `hblankPulse`, and code 3 only by `specialPulse`. Code 3 is honoured only when `CHAN_ID`=3. Pulses that do not match the timing code have no effect.
- R9: One cycle after the final unit's write completes, `irqOut` pulses for one cycle. Bit `IRQ_BASE+CHAN_ID` is set when `cfgIrqEn`=1. Bit `CART_BIT` is set when `CHAN_ID`=3 and `cfgCartReq`=1. No other bit of `irqOut` is ever set.
- R10: A channel that is inactive, or that sees `waitIn`=1 between units, starts no unit: it makes no bus request and raises no `idleCycle`.
- R11: While `busValid`=1 and `busReady`=0, the request, address and direction hold steady. The next unit begins only after the write is acknowledged. The data written equals the data returned by the unit's read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgSrc | input | 32 | Programmed source address |
| cfgDst | input | 32 | Programmed target address |
| cfgCount | input | CW | Programmed unit count |
| cfgWord | input | 1 | 1 = word units, 0 = halfword units |
| cfgSrcMode | input | 2 | Source adjust code |
| cfgDstMode | input | 2 | Target adjust code |
| cfgRepeat | input | 1 | Reload and stay enabled at block end |
| cfgIrqEn | input | 1 | Raise the channel interrupt at block end |
| cfgCartReq | input | 1 | Raise the cartridge interrupt at block end (channel 3 only) |
| cfgTiming | input | 2 | Start timing code: 0 immediate, 1 vblank, 2 hblank, 3 special |
| enWr | input | 1 | Enable-bit write strobe |
| enData | input | 1 | Value written to the enable bit |
| vblankPulse | input | 1 | Vertical-blank trigger |
| hblankPulse | input | 1 | Horizontal-blank trigger |
| specialPulse | input | 1 | Special trigger |
| waitIn | input | 1 | Hold off the next unit |
| busValid | output | 1 | Bus request |
| busWrite | output | 1 | 1 = write, 0 = read |
| busWord | output | 1 | Access size, 1 = word |
| busAddr | output | 32 | Aligned access address |
| busWdata | output | 32 | Write data |
| busReady | input | 1 | Bus acknowledge |
| busRdata | input | 32 | Read data |
| idleCycle | output | 1 | Engine spends this cycle idle |
| irqOut | output | IRQ_W | One-cycle interrupt pulses |
| chanEnabled | output | 1 | Enable bit |
| chanActive | output | 1 | Channel is armed and running |

## Verification
The assertions check, on every cycle, the properties that can be seen at the ports:
- bus addresses are aligned and never fall in the protected region;
- a pending request holds steady until acknowledged;
- an idle or held-off channel stays quiet;
- `irqOut` carries only its two allowed bits;
- the channel drops out of the active state at the end of a block;
- a repeated block reloads its count.

Only the bench scenarios can show the address sequences each adjust mode produces, the exact number of idle cycles from penalties and protected accesses, and the target restore and source continuation across a repeated block. They also cover the trigger selectivity of each timing code and correct data movement under a stalling bus.

// File: rtl/dmaeng_pkg.sv
package dmaeng_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEN1,
    ST_PEN2,
    ST_READ,
    ST_WRITE,
    ST_STEP
  } dmaState_t;

  typedef struct packed {
    logic loadAll;    // copy programmed values into working registers
    logic latchData;  // capture read data
    logic stepUnit;   // advance addresses and count
  } dpStrobe_t;

  localparam logic [31:0] LOW_LIMIT = 32'h0200_0000;

  function automatic logic [31:0] alignAddr(input logic [31:0] a, input logic word);
    logic [31:0] r;
    r = a;
    r[0] = 1'b0;
    if (word) r[1] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/dmaeng_datapath.sv
module dmaeng_datapath
  import dmaeng_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strb,
  input  logic [31:0]   cfgSrc,
  input  logic [31:0]   cfgDst,
  input  logic [CW-1:0] cfgCount,
  input  logic          cfgWord,
  input  logic [1:0]    cfgSrcMode,
  input  logic [1:0]    cfgDstMode,
  input  logic          cfgRepeat,
  input  logic [31:0]   busRdata,
  output logic [31:0]   rdAddr,
  output logic [31:0]   wrAddr,
  output logic [31:0]   wrData,
  output logic          srcLow,
  output logic          dstLow,
  output logic          firstUnit,
  output logic          lastUnit,
  output logic          romPair
);

  localparam logic [31:0] WORD_STEP = 32'd4;
  localparam logic [31:0] HALF_STEP = 32'd2;

  logic [31:0]   workSrc;
  logic [31:0]   workDst;
  logic [CW-1:0] workCnt;
  logic [31:0]   dataReg;
  logic [31:0]   seek;

  assign seek      = cfgWord ? WORD_STEP : HALF_STEP;
  assign rdAddr    = alignAddr(workSrc, cfgWord);
  assign wrAddr    = alignAddr(workDst, cfgWord);
  assign wrData    = dataReg;
  assign srcLow    = workSrc < LOW_LIMIT;
  assign dstLow    = workDst < LOW_LIMIT;
  assign firstUnit = workCnt == cfgCount;
  assign lastUnit  = workCnt == CW'(1);
  assign romPair   = cfgSrc[27] & cfgDst[27];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      workSrc <= '0;
      workDst <= '0;
      workCnt <= '0;
      dataReg <= '0;
    end else begin
      if (strb.loadAll) begin
        workSrc <= cfgSrc;
        workDst <= cfgDst;
        workCnt <= cfgCount;
      end
      if (strb.latchData) dataReg <= busRdata;
      if (strb.stepUnit) begin
        case (cfgSrcMode)
          2'd0:    workSrc <= workSrc + seek;
          2'd1:    workSrc <= workSrc - seek;
          default: workSrc <= workSrc;
        endcase
        case (cfgDstMode)
          2'd0, 2'd3: workDst <= workDst + seek;
          2'd1:       workDst <= workDst - seek;
          default:    workDst <= workDst;
        endcase
        if (lastUnit) begin
          if (cfgDstMode == 2'd3) workDst <= cfgDst;
          workCnt <= cfgRepeat ? cfgCount : '0;
        end else begin
          workCnt <= workCnt - CW'(1);
        end
      end
    end
  end

  // R6
  repeat_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepUnit && lastUnit && cfgRepeat && !strb.loadAll) |=> (workCnt == $past(cfgCount)));

endmodule

// File: rtl/dmaeng_ctrl.sv
module dmaeng_ctrl
  import dmaeng_pkg::*;
#(
  parameter int CHAN_ID  = 3,
  parameter int IRQ_BASE = 8,
  parameter int IRQ_W    = 16,
  parameter int CART_BIT = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enWr,
  input  logic             enData,
  input  logic [1:0]       cfgTiming,
  input  logic             cfgRepeat,
  input  logic             cfgIrqEn,
  input  logic             cfgCartReq,
  input  logic             vblankPulse,
  input  logic             hblankPulse,
  input  logic             specialPulse,
  input  logic             waitIn,
  input  logic             srcLow,
  input  logic             dstLow,
  input  logic             firstUnit,
  input  logic             lastUnit,
  input  logic             romPair,
  input  logic             busReady,
  output dpStrobe_t        strb,
  output logic             busValid,
  output logic             busWrite,
  output logic             idleCycle,
  output logic [IRQ_W-1:0] irqOut,
  output logic             chanEnabled,
  output logic             chanActive
);

  localparam int IRQ_POS = IRQ_BASE + CHAN_ID;
  localparam logic [IRQ_W-1:0] CHAN_MASK = IRQ_W'(1) << IRQ_POS;
  localparam logic [IRQ_W-1:0] CART_MASK = (CHAN_ID == 3) ? (IRQ_W'(1) << CART_BIT) : '0;

  dmaState_t state, stateNx;
  logic      specialArm;
  logic      cartAllowed;
  logic      blockDone;

  generate
    if (CHAN_ID == 3) begin : g_special
      assign specialArm  = specialPulse && cfgTiming == 2'd3;
      assign cartAllowed = cfgCartReq;
    end else begin : g_plain
      assign specialArm  = 1'b0;
      assign cartAllowed = 1'b0;
    end
  endgenerate

  always_comb begin
    stateNx   = state;
    strb      = '0;
    busValid  = 1'b0;
    busWrite  = 1'b0;
    idleCycle = 1'b0;
    strb.loadAll = enWr && enData && !chanEnabled;
    case (state)
      ST_IDLE: begin
        if (chanActive && !waitIn)
          stateNx = (firstUnit && !romPair) ? ST_PEN1 : ST_READ;
      end
      ST_PEN1: begin
        idleCycle = 1'b1;
        stateNx   = ST_PEN2;
      end
      ST_PEN2: begin
        idleCycle = 1'b1;
        stateNx   = ST_READ;
      end
      ST_READ: begin
        if (srcLow) begin
          idleCycle = 1'b1;
          stateNx   = ST_WRITE;
        end else begin
          busValid = 1'b1;
          if (busReady) begin
            strb.latchData = 1'b1;
            stateNx        = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        if (dstLow) begin
          idleCycle = 1'b1;
          stateNx   = ST_STEP;
        end else begin
          busValid = 1'b1;
          busWrite = 1'b1;
          if (busReady) stateNx = ST_STEP;
        end
      end
      ST_STEP: begin
        strb.stepUnit = 1'b1;
        stateNx       = ST_IDLE;
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  assign blockDone = strb.stepUnit && lastUnit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      chanEnabled <= 1'b0;
      chanActive  <= 1'b0;
      irqOut      <= '0;
    end else begin
      state  <= stateNx;
      irqOut <= '0;
      if (blockDone) begin
        chanActive <= 1'b0;
        if (!cfgRepeat) chanEnabled <= 1'b0;
        if (cfgIrqEn) irqOut[IRQ_POS] <= 1'b1;
        if (cartAllowed) irqOut <= (cfgIrqEn ? CHAN_MASK : '0) | CART_MASK;
      end
      if (chanEnabled && ((vblankPulse && cfgTiming == 2'd1) ||
                          (hblankPulse && cfgTiming == 2'd2) || specialArm))
        chanActive <= 1'b1;
      if (enWr) begin
        chanEnabled <= enData;
        if (!enData) chanActive <= 1'b0;
        else if (!chanEnabled && cfgTiming == 2'd0) chanActive <= 1'b1;
      end
    end
  end

  // R11
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> (busValid && $stable(busWrite)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && (!chanActive || waitIn)) |=> (!busValid && !idleCycle));

  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut & ~(CHAN_MASK | CART_MASK)) == '0);

  // R6
  done_inactive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blockDone && !vblankPulse && !hblankPulse && !specialPulse && !enWr) |=> !chanActive);

endmodule

// File: rtl/dma_channel_engine.sv
module dma_channel_engine
  import dmaeng_pkg::*;
#(
  parameter int CW       = 16,
  parameter int CHAN_ID  = 3,
  parameter int IRQ_BASE = 8,
  parameter int IRQ_W    = 16,
  parameter int CART_BIT = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [31:0]      cfgSrc,
  input  logic [31:0]      cfgDst,
  input  logic [CW-1:0]    cfgCount,
  input  logic             cfgWord,
  input  logic [1:0]       cfgSrcMode,
  input  logic [1:0]       cfgDstMode,
  input  logic             cfgRepeat,
  input  logic             cfgIrqEn,
  input  logic             cfgCartReq,
  input  logic [1:0]       cfgTiming,
  input  logic             enWr,
  input  logic             enData,
  input  logic             vblankPulse,
  input  logic             hblankPulse,
  input  logic             specialPulse,
  input  logic             waitIn,
  output logic             busValid,
  output logic             busWrite,
  output logic             busWord,
  output logic [31:0]      busAddr,
  output logic [31:0]      busWdata,
  input  logic             busReady,
  input  logic [31:0]      busRdata,
  output logic             idleCycle,
  output logic [IRQ_W-1:0] irqOut,
  output logic             chanEnabled,
  output logic             chanActive
);

  dpStrobe_t   strb;
  logic [31:0] rdAddr, wrAddr;
  logic        srcLow, dstLow, firstUnit, lastUnit, romPair;

  dmaeng_ctrl #(
    .CHAN_ID(CHAN_ID), .IRQ_BASE(IRQ_BASE), .IRQ_W(IRQ_W), .CART_BIT(CART_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enWr(enWr), .enData(enData),
    .cfgTiming(cfgTiming), .cfgRepeat(cfgRepeat), .cfgIrqEn(cfgIrqEn),
    .cfgCartReq(cfgCartReq), .vblankPulse(vblankPulse), .hblankPulse(hblankPulse),
    .specialPulse(specialPulse), .waitIn(waitIn), .srcLow(srcLow), .dstLow(dstLow),
    .firstUnit(firstUnit), .lastUnit(lastUnit), .romPair(romPair),
    .busReady(busReady), .strb(strb), .busValid(busValid), .busWrite(busWrite),
    .idleCycle(idleCycle), .irqOut(irqOut), .chanEnabled(chanEnabled),
    .chanActive(chanActive)
  );

  dmaeng_datapath #(.CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgSrc(cfgSrc), .cfgDst(cfgDst),
    .cfgCount(cfgCount), .cfgWord(cfgWord), .cfgSrcMode(cfgSrcMode),
    .cfgDstMode(cfgDstMode), .cfgRepeat(cfgRepeat), .busRdata(busRdata),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .wrData(busWdata), .srcLow(srcLow),
    .dstLow(dstLow), .firstUnit(firstUnit), .lastUnit(lastUnit), .romPair(romPair)
  );

  assign busAddr = busWrite ? wrAddr : rdAddr;
  assign busWord = cfgWord;

  // R1
  word_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busWord) |-> (busAddr[1:0] == 2'b00));

  // R1
  half_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> (busAddr[0] == 1'b0));

  // R4
  low_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> (busAddr >= LOW_LIMIT));

endmodule

// File: tb/sim_dma_channel_engine.sv
module sim_dma_channel_engine;

  localparam int CW = 16;
  localparam int CHAN_BIT = 11;  // IRQ_BASE 8 + CHAN_ID 3
  localparam int CART_POS = 13;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] cnt;
    logic        word;
    logic [1:0]  sm;
    logic [1:0]  dm;
    logic [7:0]  rd;
    logic [7:0]  wr;
    logic [7:0]  idle;
    logic [31:0] lastRd;
    logic [31:0] lastWr;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h0300_0000, 32'h0600_0000, 16'd3, 1'b1, 2'd0, 2'd0, 8'd3, 8'd3, 8'd2, 32'h0300_0008, 32'h0600_0008},
    '{32'h0300_0011, 32'h0600_0021, 16'd2, 1'b0, 2'd1, 2'd2, 8'd2, 8'd2, 8'd2, 32'h0300_000E, 32'h0600_0020},
    '{32'h0800_0000, 32'h0A00_0000, 16'd2, 1'b1, 2'd2, 2'd3, 8'd2, 8'd2, 8'd0, 32'h0800_0000, 32'h0A00_0004},
    '{32'h0000_0100, 32'h0300_0000, 16'd2, 1'b1, 2'd0, 2'd0, 8'd0, 8'd2, 8'd4, 32'h0000_0000, 32'h0300_0004},
    '{32'h0200_0000, 32'h01FF_FFFC, 16'd1, 1'b0, 2'd0, 2'd0, 8'd1, 8'd0, 8'd3, 32'h0200_0000, 32'h0000_0000},
    '{32'h0800_0002, 32'h0300_0006, 16'd3, 1'b0, 2'd0, 2'd1, 8'd3, 8'd3, 8'd2, 32'h0800_0006, 32'h0300_0002}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [31:0] cfgSrc = '0, cfgDst = '0;
  logic [CW-1:0] cfgCount = '0;
  logic cfgWord = 1'b0, cfgRepeat = 1'b0, cfgIrqEn = 1'b0, cfgCartReq = 1'b0;
  logic [1:0] cfgSrcMode = '0, cfgDstMode = '0, cfgTiming = '0;
  logic enWr = 1'b0, enData = 1'b0;
  logic vblankPulse = 1'b0, hblankPulse = 1'b0, specialPulse = 1'b0, waitIn = 1'b0;
  logic busValid, busWrite, busWord, busReady;
  logic [31:0] busAddr, busWdata, busRdata;
  logic idleCycle, chanEnabled, chanActive;
  logic [15:0] irqOut;

  int stallSet = 0;
  int stallCnt = 0;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;

  int rdCnt = 0, wrCnt = 0, idleCnt = 0, irqCnt = 0, cartCnt = 0;
  logic [31:0] lastRdAddr = '0, lastWrAddr = '0, lastWrData = '0;
  logic [31:0] firstRdAddr = '0, firstWrAddr = '0;
  int bRd, bWr, bIdle, bIrq, bCart;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] dataOf(input logic [31:0] a);
    return a ^ 32'h5A5A_C3C3;
  endfunction

  assign busRdata = dataOf(busAddr);
  assign busReady = busValid && (stallCnt == 0);

  dma_channel_engine u0 (
    .clk(clk), .rstN(rstN), .cfgSrc(cfgSrc), .cfgDst(cfgDst), .cfgCount(cfgCount),
    .cfgWord(cfgWord), .cfgSrcMode(cfgSrcMode), .cfgDstMode(cfgDstMode),
    .cfgRepeat(cfgRepeat), .cfgIrqEn(cfgIrqEn), .cfgCartReq(cfgCartReq),
    .cfgTiming(cfgTiming), .enWr(enWr), .enData(enData), .vblankPulse(vblankPulse),
    .hblankPulse(hblankPulse), .specialPulse(specialPulse), .waitIn(waitIn),
    .busValid(busValid), .busWrite(busWrite), .busWord(busWord), .busAddr(busAddr),
    .busWdata(busWdata), .busReady(busReady), .busRdata(busRdata),
    .idleCycle(idleCycle), .irqOut(irqOut), .chanEnabled(chanEnabled),
    .chanActive(chanActive)
  );

  always @(posedge clk) begin
    if (busValid && busReady) stallCnt <= stallSet;
    else if (busValid && stallCnt != 0) stallCnt <= stallCnt - 1;
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (busValid && busReady) begin
        if (busWrite) begin
          if (wrCnt == bWr) firstWrAddr = busAddr;
          wrCnt++;
          lastWrAddr = busAddr;
          lastWrData = busWdata;
        end else begin
          if (rdCnt == bRd) firstRdAddr = busAddr;
          rdCnt++;
          lastRdAddr = busAddr;
        end
      end
      if (idleCycle) idleCnt++;
      if (irqOut[CHAN_BIT]) irqCnt++;
      if (irqOut[CART_POS]) cartCnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFail++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", nChecks + 1, nFail);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic snap();
    bRd = rdCnt; bWr = wrCnt; bIdle = idleCnt; bIrq = irqCnt; bCart = cartCnt;
  endtask

  task automatic writeEn(input logic v);
    @(negedge clk);
    enWr = 1'b1; enData = v;
    @(negedge clk);
    enWr = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      1: vblankPulse = 1'b1;
      2: hblankPulse = 1'b1;
      default: specialPulse = 1'b1;
    endcase
    @(negedge clk);
    vblankPulse = 1'b0; hblankPulse = 1'b0; specialPulse = 1'b0;
  endtask

  task automatic waitDone(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (irqCnt + cartCnt > bIrq + bCart) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic setCfg(input vec_t v, input logic rep, input logic [1:0] tim);
    cfgSrc = v.src; cfgDst = v.dst; cfgCount = v.cnt; cfgWord = v.word;
    cfgSrcMode = v.sm; cfgDstMode = v.dm; cfgRepeat = rep; cfgTiming = tim;
    cfgIrqEn = 1'b1; cfgCartReq = 1'b0;
  endtask

  initial begin
    bRd = 0; bWr = 0; bIdle = 0; bIrq = 0; bCart = 0;
    repeat (4) @(negedge clk);
    // reset state (R10, R7)
    chk("R10 reset busValid", 32'(busValid), 0);
    chk("R10 reset idleCycle", 32'(idleCycle), 0);
    chk("R9 reset irqOut", 32'(irqOut), 0);
    chk("R7 reset chanEnabled", 32'(chanEnabled), 0);
    chk("R7 reset chanActive", 32'(chanActive), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // vector table: immediate timing, no repeat
    for (int k = 0; k < NV; k++) begin
      setCfg(VECS[k], 1'b0, 2'd0);
      snap();
      writeEn(1'b1);
      waitDone(400);
      chk("R1 R2 read count", 32'(rdCnt - bRd), 32'(VECS[k].rd));
      chk("R1 R3 write count", 32'(wrCnt - bWr), 32'(VECS[k].wr));
      chk("R4 R5 idle cycles", 32'(idleCnt - bIdle), 32'(VECS[k].idle));
      if (VECS[k].rd != 0) chk("R1 R2 last read addr", lastRdAddr, VECS[k].lastRd);
      if (VECS[k].wr != 0) chk("R1 R3 last write addr", lastWrAddr, VECS[k].lastWr);
      if (VECS[k].rd != 0 && VECS[k].wr != 0)
        chk("R11 write data", lastWrData, dataOf(VECS[k].lastRd));
      chk("R9 channel irq pulses", 32'(irqCnt - bIrq), 1);
      chk("R6 enable cleared", 32'(chanEnabled), 0);
      chk("R6 inactive", 32'(chanActive), 0);
    end

    // R10: waitIn holds off an active channel
    setCfg(VECS[0], 1'b0, 2'd0);
    waitIn = 1'b1;
    snap();
    writeEn(1'b1);
    repeat (20) @(negedge clk);
    chk("R10 held: active", 32'(chanActive), 1);
    chk("R10 held: no reads", 32'(rdCnt - bRd), 0);
    chk("R10 held: no idle", 32'(idleCnt - bIdle), 0);
    waitIn = 1'b0;
    waitDone(400);
    chk("R10 released: writes", 32'(wrCnt - bWr), 3);

    // R8, R6, R3, R2: vblank timing with repeat and target reload
    setCfg('{32'h0300_0000, 32'h0600_0100, 16'd2, 1'b1, 2'd0, 2'd3, 8'd0, 8'd0, 8'd0, 32'h0, 32'h0},
           1'b1, 2'd1);
    snap();
    writeEn(1'b1);
    repeat (10) @(negedge clk);
    chk("R8 vblank mode: no start on enable", 32'(rdCnt - bRd), 0);
    pulse(2);
    repeat (10) @(negedge clk);
    chk("R8 vblank mode: hblank ignored", 32'(rdCnt - bRd), 0);
    pulse(3);
    repeat (10) @(negedge clk);
    chk("R8 vblank mode: special ignored", 32'(rdCnt - bRd), 0);
    chk("R8 vblank mode: still inactive", 32'(chanActive), 0);
    pulse(1);
    waitDone(400);
    chk("R8 vblank block writes", 32'(wrCnt - bWr), 2);
    chk("R3 first target", firstWrAddr, 32'h0600_0100);
    chk("R3 last target", lastWrAddr, 32'h0600_0104);
    chk("R6 repeat keeps enable", 32'(chanEnabled), 1);
    chk("R6 repeat inactive", 32'(chanActive), 0);
    snap();
    pulse(1);
    waitDone(400);
    chk("R6 repeat count reloaded", 32'(wrCnt - bWr), 2);
    chk("R3 target restored", firstWrAddr, 32'h0600_0100);
    chk("R2 source continues", firstRdAddr, 32'h0300_0008);
    writeEn(1'b0);
    chk("R7 disable write", 32'(chanEnabled), 0);

    // R8: hblank timing
    setCfg('{32'h0300_0000, 32'h0600_0200, 16'd1, 1'b1, 2'd0, 2'd0, 8'd0, 8'd0, 8'd0, 32'h0, 32'h0},
           1'b0, 2'd2);
    snap();
    writeEn(1'b1);
    pulse(1);
    repeat (10) @(negedge clk);
    chk("R8 hblank mode: vblank ignored", 32'(wrCnt - bWr), 0);
    pulse(2);
    waitDone(400);
    chk("R8 hblank mode: one write", 32'(wrCnt - bWr), 1);
    chk("R8 hblank target", lastWrAddr, 32'h0600_0200);

    // R8, R9: special timing with cartridge interrupt only
    setCfg('{32'h0300_0000, 32'h0600_0300, 16'd1, 1'b0, 2'd0, 2'd0, 8'd0, 8'd0, 8'd0, 32'h0, 32'h0},
           1'b0, 2'd3);
    cfgIrqEn = 1'b0;
    cfgCartReq = 1'b1;
    snap();
    writeEn(1'b1);
    repeat (10) @(negedge clk);
    chk("R8 special mode: no start on enable", 32'(rdCnt - bRd), 0);
    pulse(3);
    waitDone(400);
    chk("R8 special mode: one write", 32'(wrCnt - bWr), 1);
    chk("R9 cartridge irq", 32'(cartCnt - bCart), 1);
    chk("R9 channel irq suppressed", 32'(irqCnt - bIrq), 0);

    // R11: stalling bus
    stallSet = 3;
    setCfg(VECS[0], 1'b0, 2'd0);
    snap();
    writeEn(1'b1);
    waitDone(800);
    chk("R11 slow bus reads", 32'(rdCnt - bRd), 3);
    chk("R11 slow bus writes", 32'(wrCnt - bWr), 3);
    chk("R11 slow bus last write", lastWrAddr, 32'h0600_0008);
    chk("R11 slow bus data", lastWrData, dataOf(32'h0300_0008));
    chk("R4 R5 slow bus idle", 32'(idleCnt - bIdle), 2);

    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

endmodule